// File: doc/BRIEF.md
# Gated PCM Transmit Serial Port

This block turns an 8-bit companded PCM word into a serial bit stream for a timeslot on a shared data line. All logic runs on one fast system clock. The transmit data clock, the frame sync and the transmit enable arrive as level inputs and are sampled on that clock. The effective shift clock is the AND of the enable and the data clock. Each rising edge of that product puts the next bit on the serial output, sign bit first. The output-enable for the external three-state driver follows the transmit enable.

A parallel word is captured into a holding register whenever its valid flag is high. The first rise of the enable after a frame sync rise produces a one-cycle transmit strobe. That strobe tells the converter to start its next sample, and the same event moves the held word, in the selected line format, into the shift register. The shift register rotates, so a word can be read out more than once. The enable can stay high for a whole byte, or it can be pulsed one bit at a time for bit-interleaved slots, and shifting resumes at the bit where it stopped.

Top module: `pcm_tx_port`

## Requirements
- R1: `tx_strobe` is a single-cycle pulse. It goes high in the clock cycle after the system clock samples the first rise of `en` that follows a rise of `fs`. A rise of `fs` and `en` sampled on the same edge counts. Further rises of `en` before the next `fs` rise give no pulse.
- R2: The strobe event copies the formatted holding word into the shift register. The first bit sent afterwards is bit 7, the sign bit.
- R3: Each sampled rise of (`en` AND `tdc`) updates `tx_data` one cycle later with the next bit, from bit 7 down to bit 0. Without such a rise, `tx_data` holds its value, including while `tdc` toggles with `en` low.
- R4: `tx_oe` is high exactly while `en` is high.
- R5: After the 8 bits of a word, further shift-clock rises send the same word again, starting at bit 7, and no strobe is produced.
- R6: If `en` drops in the middle of a word, shifting resumes at the next unsent bit when `en` and `tdc` next rise together.
- R7: With `fs` and `en` driven from the same signal, every frame gives exactly one strobe and a freshly loaded word.
- R8: `fmt_sel` selects the line format. 2'b00 and 2'b11 send the word unchanged (sign-magnitude). 2'b01 (mu-law) sends an all-zero word as 8'h02 and any other word unchanged. 2'b10 (A-law) sends the word XOR 8'h55.
- R9: `pcm_word` is captured only while `word_vld` is high. The word that a strobe loads is the last one captured.
- R10: After reset, `tx_data`, `tx_strobe` and `tx_oe` are low.
- R11: If `en` rises while `tdc` is already high, the load and the first shift happen on the same edge, and bit 7 of the new word appears one cycle after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| tdc | input | 1 | Transmit data clock level |
| fs | input | 1 | Frame sync level |
| en | input | 1 | Transmit enable; gates the data clock and the output |
| pcm_word | input | 8 | Parallel companded word |
| word_vld | input | 1 | Capture strobe for `pcm_word` |
| fmt_sel | input | 2 | Line format select |
| tx_data | output | 1 | Serial PCM data |
| tx_oe | output | 1 | Output-enable for the three-state driver |
| tx_strobe | output | 1 | One-cycle conversion-start pulse |

## Verification
If the rotating shift register or its bit position goes wrong, the damage is visible within one word. The first full byte read after a strobe comes out shifted or corrupted, and the second pass of a recirculated word does not match the first. If the frame-arming state is wrong, the result shows at the first enable rise of a frame: a strobe is missing, an extra strobe appears in the middle of a bit-interleaved word, or a stale word is reloaded. A wrong format path corrupts only the zero code or the A-law inversion pattern, so those two codes get their own cases.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int unsigned PCM_W = 8;

  typedef enum logic [1:0] {
    FMT_SIGNMAG = 2'b00,
    FMT_MU      = 2'b01,
    FMT_ALAW    = 2'b10,
    FMT_PLAIN   = 2'b11
  } fmt_e;

  localparam logic [PCM_W-1:0] MU_ZERO_SUB = 8'h02;
  localparam logic [PCM_W-1:0] ALAW_MASK   = 8'h55;

  // Line-format mapping applied when a word enters the shift register.
  function automatic logic [PCM_W-1:0] fmt_code(input logic [PCM_W-1:0] w,
                                                input fmt_e f);
    logic [PCM_W-1:0] r;
    unique case (f)
      FMT_MU:   r = (w == '0) ? MU_ZERO_SUB : w;
      FMT_ALAW: r = w ^ ALAW_MASK;
      default:  r = w;
    endcase
    return r;
  endfunction

  // One-place rotate toward the MSB; the MSB wraps into bit 0.
  function automatic logic [PCM_W-1:0] rot_left(input logic [PCM_W-1:0] w);
    return {w[PCM_W-2:0], w[PCM_W-1]};
  endfunction
endpackage

// File: rtl/pcm_tx_edge.sv
// Rising-edge detection for a vector of sampled level signals.
module pcm_tx_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pcm_tx_frame.sv
// Arms on a frame-sync rise; the next enable rise fires the strobe event.
module pcm_tx_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_rise,
  input  logic en_rise,
  output logic strobe_evt,
  output logic armed,
  output logic tx_strobe
);
  logic armed_q;

  assign strobe_evt = en_rise & (armed_q | fs_rise);
  assign armed      = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= strobe_evt;
      if (strobe_evt)   armed_q <= 1'b0;
      else if (fs_rise) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
// Rotating transmit register with a registered serial output bit.
module pcm_tx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         adv,
  output logic [W-1:0] shreg,
  output logic         bit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      bit_q <= 1'b0;
    end else if (load && adv) begin
      bit_q <= load_word[W-1];
      shreg <= {load_word[W-2:0], load_word[W-1]};
    end else if (load) begin
      shreg <= load_word;
    end else if (adv) begin
      bit_q <= shreg[W-1];
      shreg <= {shreg[W-2:0], shreg[W-1]};
    end
  end
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tdc,
  input  logic             fs,
  input  logic             en,
  input  logic [PCM_W-1:0] pcm_word,
  input  logic             word_vld,
  input  logic [1:0]       fmt_sel,
  output logic             tx_data,
  output logic             tx_oe,
  output logic             tx_strobe
);
  localparam int unsigned N_EDGE = 3;
  localparam int unsigned E_FS   = 0;
  localparam int unsigned E_EN   = 1;
  localparam int unsigned E_GATE = 2;

  logic [N_EDGE-1:0] lvl, rise;
  logic              gated_clk;
  logic              en_rise, fs_rise, shift_adv;
  logic              strobe_evt, armed;
  logic [PCM_W-1:0]  hold_q, fmt_word, shreg;

  assign gated_clk    = en & tdc;
  assign lvl[E_FS]    = fs;
  assign lvl[E_EN]    = en;
  assign lvl[E_GATE]  = gated_clk;

  pcm_tx_edge #(.N(N_EDGE)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise)
  );

  assign fs_rise   = rise[E_FS];
  assign en_rise   = rise[E_EN];
  assign shift_adv = rise[E_GATE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (word_vld) hold_q <= pcm_word;
  end

  assign fmt_word = fmt_code(hold_q, fmt_e'(fmt_sel));

  pcm_tx_frame frame_i (
    .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .en_rise(en_rise),
    .strobe_evt(strobe_evt), .armed(armed), .tx_strobe(tx_strobe)
  );

  pcm_tx_shift #(.W(PCM_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(strobe_evt), .load_word(fmt_word),
    .adv(shift_adv), .shreg(shreg), .bit_q(tx_data)
  );

  assign tx_oe = en;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_rise,
  input logic       strobe_evt,
  input logic       armed,
  input logic       shift_adv,
  input logic [7:0] fmt_word,
  input logic [7:0] shreg,
  input logic       tx_strobe,
  input logic       tx_data
);
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe);

  p_strobe_from_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_evt |=> tx_strobe);

  p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_evt |=> !armed);

  p_needs_en_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> !tx_strobe);

  p_sign_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_evt && shift_adv) |=> (tx_data == $past(fmt_word[7])));

  p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_evt && !shift_adv) |=> (shreg == $past(fmt_word)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_adv |=> $stable(tx_data));

  p_recirc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_adv && !strobe_evt) |=>
      (shreg[0] == $past(shreg[7])) && (tx_data == $past(shreg[7])));
endmodule

bind pcm_tx_port pcm_tx_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_rise(en_rise), .strobe_evt(strobe_evt),
  .armed(armed), .shift_adv(shift_adv), .fmt_word(fmt_word), .shreg(shreg),
  .tx_strobe(tx_strobe), .tx_data(tx_data)
);

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tdc = 1'b0, fs = 1'b0, en = 1'b0, word_vld = 1'b0;
  logic [7:0] pcm_word = 8'h00;
  logic [1:0] fmt_sel = 2'b00;
  logic       tx_data, tx_oe, tx_strobe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pcm_tx_port dut_i (
    .clk(clk), .rst_n(rst_n), .tdc(tdc), .fs(fs), .en(en),
    .pcm_word(pcm_word), .word_vld(word_vld), .fmt_sel(fmt_sel),
    .tx_data(tx_data), .tx_oe(tx_oe), .tx_strobe(tx_strobe)
  );

  function automatic logic [7:0] expect_line(input logic [7:0] w, input logic [1:0] s);
    if (s == 2'b10) return ~(w ^ 8'hAA);
    if (s == 2'b01 && w == 8'h00) return 8'h02;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] w);
    @(negedge clk) pcm_word = w; word_vld = 1'b1;
    @(negedge clk) word_vld = 1'b0;
  endtask

  task automatic fs_pulse();
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
  endtask

  task automatic en_up(input bit exp_strobe, input string req);
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    check(tx_strobe == exp_strobe, req, tx_strobe, exp_strobe);
    check(tx_oe == 1'b1, "R4 oe high", tx_oe, 1);
  endtask

  task automatic en_down();
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check(tx_oe == 1'b0, "R4 oe low", tx_oe, 0);
  endtask

  task automatic tdc_bit(output logic b);
    @(negedge clk) tdc = 1'b1;
    @(negedge clk) b = tx_data; tdc = 1'b0;
    check(tx_strobe == 1'b0, "R1 no strobe while shifting", tx_strobe, 0);
    @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      tdc_bit(b);
      v[i] = b;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_data == 0 && tx_strobe == 0 && tx_oe == 0, "R10 reset outputs",
          {tx_data, tx_strobe, tx_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_byte(input logic [7:0] w, input logic [1:0] s, input string req);
    logic [7:0] got;
    fmt_sel = s;
    load(w);
    fs_pulse();
    en_up(1'b1, "R1 strobe on first en rise");
    read_byte(got);
    check(got == expect_line(w, s), req, got, expect_line(w, s));
    en_down();
  endtask

  task automatic t_recirc();
    logic [7:0] a, b;
    fmt_sel = 2'b00;
    load(8'hC6);
    fs_pulse();
    en_up(1'b1, "R1 strobe");
    read_byte(a);
    read_byte(b);
    check(a == 8'hC6, "R2 first pass", a, 8'hC6);
    check(b == 8'hC6, "R5 recirculated pass", b, 8'hC6);
    en_down();
  endtask

  task automatic t_no_fs();
    logic [7:0] got;
    @(negedge clk) pcm_word = 8'h3C;
    load(8'h81);
    @(negedge clk) pcm_word = 8'h7E;
    en_up(1'b0, "R1 no strobe without frame sync");
    read_byte(got);
    check(got == 8'hC6, "R1 old word kept without strobe", got, 8'hC6);
    en_down();
    fs_pulse();
    en_up(1'b1, "R1 strobe after frame sync");
    read_byte(got);
    check(got == 8'h81, "R9 only captured word loaded", got, 8'h81);
    en_down();
  endtask

  task automatic t_bit_il();
    logic [7:0] got;
    logic b, held;
    fmt_sel = 2'b00;
    load(8'hB4);
    fs_pulse();
    for (int i = 7; i >= 0; i--) begin
      en_up(i == 7, "R6 one strobe per interleaved word");
      tdc_bit(b);
      got[i] = b;
      en_down();
      held = tx_data;
      @(negedge clk) tdc = 1'b1;
      @(negedge clk) tdc = 1'b0;
      check(tx_data == held, "R3 gated tdc gives no shift", tx_data, held);
    end
    check(got == 8'hB4, "R6 interleaved word resumes", got, 8'hB4);
  endtask

  task automatic t_tied();
    logic [7:0] got;
    fmt_sel = 2'b00;
    for (int f = 0; f < 2; f++) begin
      logic [7:0] w;
      w = (f == 0) ? 8'h5A : 8'hE1;
      load(w);
      @(negedge clk) en = 1'b1; fs = 1'b1;
      @(negedge clk);
      check(tx_strobe == 1'b1, "R7 tied frame strobe", tx_strobe, 1);
      read_byte(got);
      check(got == w, "R7 tied frame word", got, w);
      @(negedge clk) en = 1'b0; fs = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_en_tdc_high();
    logic [7:0] got;
    fmt_sel = 2'b00;
    load(8'h9D);
    fs_pulse();
    @(negedge clk) tdc = 1'b1;
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    check(tx_strobe == 1'b1, "R11 strobe", tx_strobe, 1);
    check(tx_data == 1'b1, "R11 sign bit at load", tx_data, 1);
    @(negedge clk) tdc = 1'b0;
    got[7] = 1'b1;
    for (int i = 6; i >= 0; i--) begin
      logic b;
      tdc_bit(b);
      got[i] = b;
    end
    check(got == 8'h9D, "R11 rest of word", got, 8'h9D);
    en_down();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_byte(8'hA3, 2'b00, "R8 sign-magnitude passes word");
    t_byte(8'h00, 2'b01, "R8 mu-law zero substitution");
    t_byte(8'h47, 2'b01, "R8 mu-law nonzero unchanged");
    t_byte(8'h00, 2'b10, "R8 A-law inversion of zero");
    t_byte(8'hF0, 2'b10, "R8 A-law inversion pattern");
    t_byte(8'h6B, 2'b11, "R8 select 3 passes word R3");
    t_recirc();
    t_no_fs();
    t_bit_il();
    t_tied();
    t_en_tdc_high();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule